// File: doc/BRIEF.md
# Serial Flash Bulk-Erase Controller

This controller accepts a whole-device erase request from a user command port and carries it out through a simple command interface to a serial-flash SPI engine. A request counts only when a separate write-enable qualifier is high at the same clock edge. After accepting one, the controller first reads the flash status register and checks the block-protect bits. If no bit is set, it sends the write-enable command and then the chip-erase command. It then keeps reading the status register until the write-in-progress bit clears. No address is involved, because the erase clears the whole array, including any configuration image stored in it.

Busy stays high from the cycle after acceptance until the flash reports that the erase is finished. If the device is protected, no erase is sent: busy drops and a two-cycle illegal-erase pulse reports the cancellation. A request that is still held when busy drops is taken as a new request. Callers must therefore release both inputs before the erase ends.

Each flash command is one start/done transaction with the SPI engine. The engine frames each transaction with its own chip-select, so chip select is released between commands.

Top module: `spiBulkEraseCtl`

## Requirements
- R1: When writeEn and eraseReq are both 1 at a rising clock edge and the block is idle with no illegal pulse active, busy is 1 in the cycle after that edge.
- R2: When writeEn is 0, eraseReq has no effect: busy stays 0 and no command is started.
- R3: An accepted erase issues commands in this order: status read (opcode 0x05, cmdRead=1), write-enable (0x06, cmdRead=0), chip erase (0xC7, cmdRead=0), then status reads (0x05, cmdRead=1) repeated until bit 0 of the returned byte is 0. cmdStart is a one-cycle pulse, and the next command starts only after cmdDone for the previous one.
- R4: Busy stays 1 throughout the erase and falls in the cycle after the cmdDone of the status read whose bit 0 is 0.
- R5: If the first status read returns a nonzero value in bits [4:2] (block protect), neither 0x06 nor 0xC7 is issued. Busy falls in the cycle after that cmdDone, and in that same cycle illegalErase rises for exactly 2 cycles.
- R6: If writeEn and eraseReq are still 1 when busy falls, a new erase starts: busy is 0 for exactly one cycle and then 1 again, and the sequence restarts with a status read.
- R7: Requests are not sampled while busy is 1 or while illegalErase is 1. Busy is never 1 while illegalErase is 1.
- R8: A synchronous reset returns the block to idle with busy, illegalErase and cmdStart all 0, even in the middle of an erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| writeEn | input | 1 | Write-enable qualifier for the erase request |
| eraseReq | input | 1 | Whole-device erase request |
| busy | output | 1 | High while an erase sequence runs |
| illegalErase | output | 1 | Two-cycle pulse when the erase is refused due to protection |
| cmdStart | output | 1 | One-cycle start strobe to the SPI engine |
| cmdOpcode | output | 8 | Flash opcode for the current command |
| cmdRead | output | 1 | High when the command returns one status byte |
| cmdDone | input | 1 | One-cycle completion strobe from the SPI engine |
| cmdRdData | input | 8 | Status byte returned with cmdDone |

## Verification
The bench builds the block with its default parameters: 8-bit opcodes and status, a protect mask on bits [4:2], write-in-progress on bit 0, and a two-cycle illegal pulse. With these values the standard command codes can be checked directly. A behavioural flash model returns status after a fixed latency. Its protect bits and its number of busy polls can be set, so the bench can run erases with zero and several busy polls, refused erases with the inputs released or held, back-to-back retriggers, and a reset in the middle of an erase.

// File: rtl/bulkEraseCtlPkg.sv
package bulkEraseCtlPkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT} phase_e;
  typedef enum logic [1:0] {ST_CHECK, ST_WREN, ST_ERASE, ST_POLL} step_e;
  typedef struct packed {
    logic  issue;
    step_e step;
    logic  flagIllegal;
  } dpStrobe_t;
endpackage

// File: rtl/eraseSeqCtrl.sv
module eraseSeqCtrl
  import bulkEraseCtlPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      writeEn,
  input  logic      eraseReq,
  input  logic      illegalActive,
  input  logic      cmdDone,
  input  logic      protHit,
  input  logic      wipSet,
  output dpStrobe_t strobe,
  output logic      busy
);
  phase_e phase;
  step_e  step;
  logic   acceptReq;

  assign acceptReq = (phase == PH_IDLE) && writeEn && eraseReq && !illegalActive;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      step  <= ST_CHECK;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (acceptReq) begin
            phase <= PH_ISSUE;
            step  <= ST_CHECK;
          end
        end
        PH_ISSUE: phase <= PH_WAIT;
        PH_WAIT: begin
          if (cmdDone) begin
            case (step)
              ST_CHECK: begin
                if (protHit) phase <= PH_IDLE;
                else begin
                  step  <= ST_WREN;
                  phase <= PH_ISSUE;
                end
              end
              ST_WREN: begin
                step  <= ST_ERASE;
                phase <= PH_ISSUE;
              end
              ST_ERASE: begin
                step  <= ST_POLL;
                phase <= PH_ISSUE;
              end
              default: phase <= wipSet ? PH_ISSUE : PH_IDLE;
            endcase
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.issue       = (phase == PH_ISSUE);
    strobe.step        = step;
    strobe.flagIllegal = (phase == PH_WAIT) && cmdDone && (step == ST_CHECK) && protHit;
    busy               = (phase != PH_IDLE);
  end

  // R1: a qualified request raises busy one cycle later
  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && writeEn && eraseReq && !illegalActive) |=> busy);
  // R2: without write-enable an idle block stays idle
  p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !writeEn) |=> !busy);
  // R5: a refused erase ends the busy period
  p_refuse_idle_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.flagIllegal |=> !busy);
  // R7: busy and the illegal pulse never overlap
  p_illegal_idle_r7: assert property (@(posedge clk) disable iff (rst)
    illegalActive |-> !busy);
endmodule

// File: rtl/eraseSeqDatapath.sv
module eraseSeqDatapath
  import bulkEraseCtlPkg::*;
#(
  parameter int              OP_W      = 8,
  parameter int              STAT_W    = 8,
  parameter logic [STAT_W-1:0] PROT_MASK = 8'h1C,
  parameter int              WIP_BIT   = 0,
  parameter logic [OP_W-1:0] OP_RDSR   = 8'h05,
  parameter logic [OP_W-1:0] OP_WREN   = 8'h06,
  parameter logic [OP_W-1:0] OP_CE     = 8'hC7,
  parameter int              PULSE_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [STAT_W-1:0] cmdRdData,
  output logic              cmdStart,
  output logic [OP_W-1:0]   cmdOpcode,
  output logic              cmdRead,
  output logic              protHit,
  output logic              wipSet,
  output logic              illegalActive,
  output logic              illegalErase
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] pulseCnt;

  always_comb begin
    case (strobe.step)
      ST_WREN:  cmdOpcode = OP_WREN;
      ST_ERASE: cmdOpcode = OP_CE;
      default:  cmdOpcode = OP_RDSR;
    endcase
  end

  assign cmdRead  = (strobe.step == ST_CHECK) || (strobe.step == ST_POLL);
  assign cmdStart = strobe.issue;
  assign protHit  = |(cmdRdData & PROT_MASK);
  assign wipSet   = cmdRdData[WIP_BIT];

  always_ff @(posedge clk) begin
    if (rst) pulseCnt <= '0;
    else if (strobe.flagIllegal) pulseCnt <= CNT_W'(PULSE_LEN);
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
  end

  assign illegalActive = (pulseCnt != '0);
  assign illegalErase  = illegalActive;

  // R3: each command start is a single-cycle strobe
  p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
    cmdStart |=> !cmdStart);
  // R5: the illegal pulse lasts longer than one cycle
  p_pulse_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(illegalErase) |=> illegalErase);
  // R5: no command is launched while the refusal is being reported
  p_no_cmd_in_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    illegalErase |-> !cmdStart);
endmodule

// File: rtl/spiBulkEraseCtl.sv
module spiBulkEraseCtl
  import bulkEraseCtlPkg::*;
#(
  parameter int OP_W   = 8,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              writeEn,
  input  logic              eraseReq,
  output logic              busy,
  output logic              illegalErase,
  output logic              cmdStart,
  output logic [OP_W-1:0]   cmdOpcode,
  output logic              cmdRead,
  input  logic              cmdDone,
  input  logic [STAT_W-1:0] cmdRdData
);
  dpStrobe_t strobe;
  logic      protHit;
  logic      wipSet;
  logic      illegalActive;

  eraseSeqCtrl uCtrl (
    .clk(clk), .rst(rst), .writeEn(writeEn), .eraseReq(eraseReq),
    .illegalActive(illegalActive), .cmdDone(cmdDone), .protHit(protHit),
    .wipSet(wipSet), .strobe(strobe), .busy(busy)
  );

  eraseSeqDatapath #(.OP_W(OP_W), .STAT_W(STAT_W)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .cmdRdData(cmdRdData),
    .cmdStart(cmdStart), .cmdOpcode(cmdOpcode), .cmdRead(cmdRead),
    .protHit(protHit), .wipSet(wipSet), .illegalActive(illegalActive),
    .illegalErase(illegalErase)
  );

  // R4: busy only falls when a command has just completed (or on reset)
  p_busy_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmdDone) |=> busy);
endmodule

// File: tb/spiBulkEraseCtl_test.sv
module spiBulkEraseCtl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst, writeEn, eraseReq;
  logic busy, illegalErase, cmdStart, cmdRead;
  logic [7:0] cmdOpcode;
  logic cmdDone;
  logic [7:0] cmdRdData;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] opLog [0:31];
  int logCount = 0, readMismatch = 0, overlap = 0;
  int lastDoneEdge = 0, edgeCount = 0;
  logic [2:0] protBits = 3'b000;
  int erasePolls = 0, wipLeft = 0, delay = 0;
  logic [7:0] curOp = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiBulkEraseCtl uut (
    .clk(clk), .rst(rst), .writeEn(writeEn), .eraseReq(eraseReq),
    .busy(busy), .illegalErase(illegalErase), .cmdStart(cmdStart),
    .cmdOpcode(cmdOpcode), .cmdRead(cmdRead), .cmdDone(cmdDone),
    .cmdRdData(cmdRdData)
  );

  // behavioural flash behind the SPI engine
  always @(posedge clk) begin
    edgeCount++;
    cmdDone <= 1'b0;
    if (cmdStart) begin
      if (delay != 0) overlap++;
      if (logCount < 32) opLog[logCount] = cmdOpcode;
      logCount++;
      if (cmdRead != (cmdOpcode == 8'h05)) readMismatch++;
      curOp = cmdOpcode;
      delay = 3;
    end else if (delay > 0) begin
      delay--;
      if (delay == 0) begin
        cmdDone <= 1'b1;
        if (curOp == 8'h05) begin
          cmdRdData <= {3'b000, protBits, 1'b0, (wipLeft > 0)};
          if (wipLeft > 0) wipLeft--;
          else lastDoneEdge = edgeCount;
        end else begin
          if (curOp == 8'hC7) wipLeft = erasePolls;
          cmdRdData <= 8'h00;
        end
      end
    end
  end

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000 && (busy || illegalErase); i++) @(negedge clk);
  endtask

  task automatic tReset();
    rst = 1; writeEn = 0; eraseReq = 0;
    repeat (3) @(negedge clk);
    chkEq("R8 busy in reset", busy, 0);
    chkEq("R8 illegal in reset", illegalErase, 0);
    chkEq("R8 start in reset", cmdStart, 0);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic tIgnore();
    int seen = 0;
    logCount = 0;
    writeEn = 0; eraseReq = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); seen += busy; end
    writeEn = 1; eraseReq = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); seen += busy; end
    writeEn = 0;
    chkEq("R2 busy with writeEn low", seen, 0);
    chkEq("R2 commands with writeEn low", logCount, 0);
  endtask

  task automatic tErase(input int polls);
    bit orderOk = 1;
    erasePolls = polls; protBits = 3'b000; logCount = 0;
    readMismatch = 0; overlap = 0;
    writeEn = 1; eraseReq = 1;
    @(negedge clk);
    chkEq("R1 busy after accept", busy, 1);
    writeEn = 0; eraseReq = 0;
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    chkEq("R4 busy fall edge", edgeCount, lastDoneEdge + 1);
    chkEq("R3 command count", logCount, 4 + polls);
    if (opLog[0] != 8'h05 || opLog[1] != 8'h06 || opLog[2] != 8'hC7) orderOk = 0;
    for (int k = 3; k < 4 + polls; k++) if (opLog[k] != 8'h05) orderOk = 0;
    chkEq("R3 opcode order", orderOk, 1);
    chkEq("R3 read flag", readMismatch, 0);
    chkEq("R3 start before done", overlap, 0);
    chkEq("R4 illegal stays low", illegalErase, 0);
  endtask

  task automatic tProtect(input bit held);
    int pulse = 0;
    erasePolls = 0; protBits = 3'b100; logCount = 0;
    writeEn = 1; eraseReq = 1;
    @(negedge clk);
    if (!held) begin writeEn = 0; eraseReq = 0; end
    for (int i = 0; i < 100 && !illegalErase; i++) @(negedge clk);
    chkEq("R5 busy low at illegal rise", busy, 0);
    while (illegalErase && pulse < 10) begin
      pulse++;
      if (busy) pulse += 100;
      @(negedge clk);
    end
    chkEq("R5 illegal pulse length", pulse, 2);
    if (held) begin
      chkEq("R7 no sample during pulse", busy, 0);
      @(negedge clk);
      chkEq("R6 held request after pulse", busy, 1);
      writeEn = 0; eraseReq = 0;
      waitIdle();
    end else begin
      chkEq("R5 only status read issued", logCount, 1);
      chkEq("R5 first opcode", opLog[0], 8'h05);
    end
    protBits = 3'b000;
    repeat (2) @(negedge clk);
  endtask

  task automatic tRetrigger();
    int lowCycles = 0;
    erasePolls = 1; protBits = 3'b000; logCount = 0;
    writeEn = 1; eraseReq = 1;
    @(negedge clk);
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    chkEq("R7 commands in first erase", logCount, 5);
    while (!busy && lowCycles < 10) begin lowCycles++; @(negedge clk); end
    chkEq("R6 idle gap before retrigger", lowCycles, 1);
    writeEn = 0; eraseReq = 0;
    waitIdle();
    chkEq("R6 second sequence ran", logCount, 10);
    chkEq("R6 second sequence restarts with read", opLog[5], 8'h05);
  endtask

  task automatic tResetMid();
    erasePolls = 20; logCount = 0;
    writeEn = 1; eraseReq = 1;
    @(negedge clk);
    writeEn = 0; eraseReq = 0;
    repeat (12) @(negedge clk);
    rst = 1;
    @(negedge clk);
    delay = 0; wipLeft = 0;
    rst = 0;
    @(negedge clk);
    chkEq("R8 busy after mid reset", busy, 0);
    chkEq("R8 start after mid reset", cmdStart, 0);
    repeat (10) @(negedge clk);
    chkEq("R8 stays idle", busy, 0);
  endtask

  initial begin
    tReset();
    tIgnore();
    tErase(0);
    tErase(3);
    tProtect(0);
    tProtect(1);
    tRetrigger();
    tResetMid();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule